// File: doc/BRIEF.md
# VPID-Tagged Translation Cache Invalidation Engine

This block holds a small, fully associative cache of address translations. Each entry carries five tags: a 16-bit virtual-processor identifier (VPID), a linear page number, a process-context tag, an extended-page-table pointer tag and a global flag. A fill port writes an entry into a chosen slot. A lookup port asks whether a valid entry with a given set of tags is present.

An invalidation command has three fields: a two-bit kind, a VPID and a full linear address. The engine accepts one command at a time through a valid/ready handshake. It then walks the entries one per clock and clears the valid bit of every entry that the command selects. Selection uses the VPID tag, the page number and the global flag only. The process-context and page-table-pointer tags never take part. Entries tagged with VPID 0 survive every kind of command. Operand checking is done upstream, so every command that reaches the block is carried out.

Top module: `vpid_inval_engine`

## Requirements
- R1: Kind 0 (cmd_type = 2'd0) clears only valid entries whose VPID equals cmd_vpid and whose page number equals cmd_addr with the low 12 offset bits dropped. The offset bits have no effect on selection.
- R2: Kind 1 (cmd_type = 2'd1) clears every valid entry whose VPID equals cmd_vpid, whatever its page number or global flag.
- R3: Kind 2 (cmd_type = 2'd2) clears every valid entry with a non-zero VPID, whatever the value of cmd_vpid.
- R4: Kind 3 (cmd_type = 2'd3) clears every valid entry whose VPID equals cmd_vpid, except entries whose global flag is 1.
- R5: Selection for invalidation ignores an entry's process-context and page-table-pointer tags. Entries that differ only in those tags are treated alike.
- R6: No command of any kind clears an entry whose VPID tag is 0.
- R7: From the clock after a command is accepted, busy is high for exactly ENTRIES cycles, one entry visited per cycle. It is followed by a one-cycle done pulse, during which busy is low.
- R8: cmd_ready is low while busy is high, and a command offered then is not taken. A command is accepted on a clock where cmd_valid and cmd_ready are both high.
- R9: lk_ready is low while busy is high, and a request offered then gets no response. An accepted request gives lk_rsp_valid one cycle later. lk_hit is 1 only if a valid entry matches all four of VPID, page number, process-context and page-table-pointer tags.
- R10: fill_en writes the given tags into slot fill_idx and marks it valid, but only when busy is low. A fill offered during a sweep is dropped.
- R11: Reset clears every valid bit, and leaves busy, done and lk_rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Invalidation command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_type | input | 2 | Invalidation kind, 0 to 3 |
| cmd_vpid | input | VPID_W | VPID named by the command |
| cmd_addr | input | VA_W | Linear address named by the command |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when the sweep ends |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | IDX_W | Slot to write |
| fill_vpid | input | VPID_W | VPID tag of the new entry |
| fill_lpn | input | LPN_W | Page number tag of the new entry |
| fill_pcid | input | PCID_W | Process-context tag of the new entry |
| fill_eptp | input | EPTP_W | Page-table-pointer tag of the new entry |
| fill_global | input | 1 | Global flag of the new entry |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be taken |
| lk_vpid | input | VPID_W | Lookup VPID |
| lk_lpn | input | LPN_W | Lookup page number |
| lk_pcid | input | PCID_W | Lookup process-context tag |
| lk_eptp | input | EPTP_W | Lookup page-table-pointer tag |
| lk_rsp_valid | output | 1 | Lookup response present |
| lk_hit | output | 1 | Lookup found a valid matching entry |

## Verification
The cache is loaded with one table that mixes the cases each kind must tell apart. The table has entries of one VPID on the same page under different process-context and pointer tags, a global and a non-global entry of the same VPID, and entries tagged VPID 0. The four kinds are then issued in turn, and every slot is looked up after each one. This shows whether a kind also removes a neighbour it should have spared, such as another page, a global entry or a VPID-0 entry. The kind-0 command carries a non-zero page offset, which shows whether offset bits take part in page matching. Kind 2 is issued with a VPID field that matches no entry, which shows whether it ignores that field. A final sweep is probed mid-flight with a lookup, a fill and a second command, to show that all three are held off or dropped.

// File: rtl/vit_pkg.sv
package vit_pkg;
  typedef enum logic [1:0] {
    INV_PAGE      = 2'd0,
    INV_CTX       = 2'd1,
    INV_ALL_NZ    = 2'd2,
    INV_CTX_KEEPG = 2'd3
  } inv_kind_e;

  localparam int unsigned PAGE_OFS_W = 12;
endpackage

// File: rtl/vit_entry_store.sv
module vit_entry_store #(
  parameter int unsigned N      = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned VPID_W = 16,
  parameter int unsigned LPN_W  = 36,
  parameter int unsigned PCID_W = 12,
  parameter int unsigned EPTP_W = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [VPID_W-1:0]            wr_vpid,
  input  logic [LPN_W-1:0]             wr_lpn,
  input  logic [PCID_W-1:0]            wr_pcid,
  input  logic [EPTP_W-1:0]            wr_eptp,
  input  logic                         wr_glb,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_idx,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic                         rd_vld,
  output logic [VPID_W-1:0]            rd_vpid,
  output logic [LPN_W-1:0]             rd_lpn,
  output logic                         rd_glb,
  output logic [N-1:0]                 all_vld,
  output logic [N-1:0][VPID_W-1:0]     all_vpid,
  output logic [N-1:0][LPN_W-1:0]      all_lpn,
  output logic [N-1:0][PCID_W-1:0]     all_pcid,
  output logic [N-1:0][EPTP_W-1:0]     all_eptp
);
  logic [N-1:0]             vld_q;
  logic [N-1:0]             glb_q;
  logic [N-1:0][VPID_W-1:0] vpid_q;
  logic [N-1:0][LPN_W-1:0]  lpn_q;
  logic [N-1:0][PCID_W-1:0] pcid_q;
  logic [N-1:0][EPTP_W-1:0] eptp_q;

  // Tags carry no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpid_q[wr_idx] <= wr_vpid;
      lpn_q[wr_idx]  <= wr_lpn;
      pcid_q[wr_idx] <= wr_pcid;
      eptp_q[wr_idx] <= wr_eptp;
      glb_q[wr_idx]  <= wr_glb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_idx]  <= 1'b1;
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  assign rd_vld   = vld_q[rd_idx];
  assign rd_vpid  = vpid_q[rd_idx];
  assign rd_lpn   = lpn_q[rd_idx];
  assign rd_glb   = glb_q[rd_idx];
  assign all_vld  = vld_q;
  assign all_vpid = vpid_q;
  assign all_lpn  = lpn_q;
  assign all_pcid = pcid_q;
  assign all_eptp = eptp_q;
endmodule

// File: rtl/vit_kill_match.sv
module vit_kill_match
  import vit_pkg::*;
#(
  parameter int unsigned VPID_W = 16,
  parameter int unsigned LPN_W  = 36
) (
  input  logic              ent_vld,
  input  logic [VPID_W-1:0] ent_vpid,
  input  logic [LPN_W-1:0]  ent_lpn,
  input  logic              ent_glb,
  input  inv_kind_e         kind,
  input  logic [VPID_W-1:0] cmd_vpid,
  input  logic [LPN_W-1:0]  cmd_lpn,
  output logic              kill
);
  logic tag_nz;
  logic same_vpid;
  logic same_page;
  logic sel;

  assign tag_nz    = |ent_vpid;
  assign same_vpid = (ent_vpid == cmd_vpid);
  assign same_page = (ent_lpn == cmd_lpn);

  always_comb begin
    unique case (kind)
      INV_PAGE:      sel = same_vpid && same_page;
      INV_CTX:       sel = same_vpid;
      INV_ALL_NZ:    sel = 1'b1;
      INV_CTX_KEEPG: sel = same_vpid && !ent_glb;
      default:       sel = 1'b0;
    endcase
  end

  assign kill = ent_vld && tag_nz && sel;
endmodule

// File: rtl/vit_sweep_ctrl.sv
module vit_sweep_ctrl
  import vit_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned VPID_W = 16,
  parameter int unsigned LPN_W  = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [VPID_W-1:0] cmd_vpid,
  input  logic [LPN_W-1:0]  cmd_lpn,
  input  logic              kill,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  cur_idx,
  output inv_kind_e         cur_kind,
  output logic [VPID_W-1:0] cur_vpid,
  output logic [LPN_W-1:0]  cur_lpn,
  output logic              clr_en
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic busy_q;
  logic done_q;
  logic accept;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cur_idx <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cur_idx <= '0;
      end else if (busy_q) begin
        if (cur_idx == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_idx <= cur_idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_kind <= INV_PAGE;
      cur_vpid <= '0;
      cur_lpn  <= '0;
    end else if (accept) begin
      cur_kind <= inv_kind_e'(cmd_type);
      cur_vpid <= cmd_vpid;
      cur_lpn  <= cmd_lpn;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign clr_en = busy_q && kill;
endmodule

// File: rtl/vit_lookup.sv
module vit_lookup #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPID_W = 16,
  parameter int unsigned LPN_W  = 36,
  parameter int unsigned PCID_W = 12,
  parameter int unsigned EPTP_W = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [VPID_W-1:0]        q_vpid,
  input  logic [LPN_W-1:0]         q_lpn,
  input  logic [PCID_W-1:0]        q_pcid,
  input  logic [EPTP_W-1:0]        q_eptp,
  input  logic [N-1:0]             all_vld,
  input  logic [N-1:0][VPID_W-1:0] all_vpid,
  input  logic [N-1:0][LPN_W-1:0]  all_lpn,
  input  logic [N-1:0][PCID_W-1:0] all_pcid,
  input  logic [N-1:0][EPTP_W-1:0] all_eptp,
  output logic                     rsp_valid,
  output logic                     hit
);
  logic [N-1:0] way_hit;

  for (genvar g = 0; g < N; g++) begin : g_way
    assign way_hit[g] = all_vld[g]
                     && (all_vpid[g] == q_vpid)
                     && (all_lpn[g]  == q_lpn)
                     && (all_pcid[g] == q_pcid)
                     && (all_eptp[g] == q_eptp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      hit       <= 1'b0;
    end else begin
      rsp_valid <= req;
      hit       <= req && (|way_hit);
    end
  end
endmodule

// File: rtl/vpid_inval_engine.sv
module vpid_inval_engine
  import vit_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPID_W  = 16,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PCID_W  = 12,
  parameter int unsigned EPTP_W  = 40,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LPN_W  = VA_W - PAGE_OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_type,
  input  logic [VPID_W-1:0] cmd_vpid,
  input  logic [VA_W-1:0]   cmd_addr,
  output logic              busy,
  output logic              done,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPID_W-1:0] fill_vpid,
  input  logic [LPN_W-1:0]  fill_lpn,
  input  logic [PCID_W-1:0] fill_pcid,
  input  logic [EPTP_W-1:0] fill_eptp,
  input  logic              fill_global,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPID_W-1:0] lk_vpid,
  input  logic [LPN_W-1:0]  lk_lpn,
  input  logic [PCID_W-1:0] lk_pcid,
  input  logic [EPTP_W-1:0] lk_eptp,
  output logic              lk_rsp_valid,
  output logic              lk_hit
);
  logic                      unused_ofs;
  logic [LPN_W-1:0]          cmd_lpn;
  logic                      kill;
  logic                      clr_en;
  logic [IDX_W-1:0]          cur_idx;
  inv_kind_e                 cur_kind;
  logic [VPID_W-1:0]         cur_vpid;
  logic [LPN_W-1:0]          cur_lpn;
  logic                      rd_vld;
  logic [VPID_W-1:0]         rd_vpid;
  logic [LPN_W-1:0]          rd_lpn;
  logic                      rd_glb;
  logic [ENTRIES-1:0]              all_vld;
  logic [ENTRIES-1:0][VPID_W-1:0]  all_vpid;
  logic [ENTRIES-1:0][LPN_W-1:0]   all_lpn;
  logic [ENTRIES-1:0][PCID_W-1:0]  all_pcid;
  logic [ENTRIES-1:0][EPTP_W-1:0]  all_eptp;

  assign cmd_lpn    = cmd_addr[VA_W-1:PAGE_OFS_W];
  assign unused_ofs = ^cmd_addr[PAGE_OFS_W-1:0];
  assign lk_ready   = !busy;

  vit_sweep_ctrl #(
    .N(ENTRIES), .IDX_W(IDX_W), .VPID_W(VPID_W), .LPN_W(LPN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_vpid(cmd_vpid), .cmd_lpn(cmd_lpn),
    .kill(kill),
    .cmd_ready(cmd_ready), .busy(busy), .done(done),
    .cur_idx(cur_idx), .cur_kind(cur_kind),
    .cur_vpid(cur_vpid), .cur_lpn(cur_lpn),
    .clr_en(clr_en)
  );

  vit_entry_store #(
    .N(ENTRIES), .IDX_W(IDX_W), .VPID_W(VPID_W), .LPN_W(LPN_W),
    .PCID_W(PCID_W), .EPTP_W(EPTP_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(fill_en && !busy), .wr_idx(fill_idx),
    .wr_vpid(fill_vpid), .wr_lpn(fill_lpn),
    .wr_pcid(fill_pcid), .wr_eptp(fill_eptp), .wr_glb(fill_global),
    .clr_en(clr_en), .clr_idx(cur_idx),
    .rd_idx(cur_idx),
    .rd_vld(rd_vld), .rd_vpid(rd_vpid), .rd_lpn(rd_lpn), .rd_glb(rd_glb),
    .all_vld(all_vld), .all_vpid(all_vpid), .all_lpn(all_lpn),
    .all_pcid(all_pcid), .all_eptp(all_eptp)
  );

  vit_kill_match #(
    .VPID_W(VPID_W), .LPN_W(LPN_W)
  ) u_match (
    .ent_vld(rd_vld), .ent_vpid(rd_vpid), .ent_lpn(rd_lpn), .ent_glb(rd_glb),
    .kind(cur_kind), .cmd_vpid(cur_vpid), .cmd_lpn(cur_lpn),
    .kill(kill)
  );

  vit_lookup #(
    .N(ENTRIES), .VPID_W(VPID_W), .LPN_W(LPN_W),
    .PCID_W(PCID_W), .EPTP_W(EPTP_W)
  ) u_lookup (
    .clk(clk), .rst(rst),
    .req(lk_valid && !busy),
    .q_vpid(lk_vpid), .q_lpn(lk_lpn), .q_pcid(lk_pcid), .q_eptp(lk_eptp),
    .all_vld(all_vld), .all_vpid(all_vpid), .all_lpn(all_lpn),
    .all_pcid(all_pcid), .all_eptp(all_eptp),
    .rsp_valid(lk_rsp_valid), .hit(lk_hit)
  );
endmodule

// File: rtl/vpid_inval_engine_chk.sv
module vpid_inval_engine_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic lk_valid,
  input logic lk_ready,
  input logic lk_rsp_valid
);
  localparam int unsigned CNT_W = $clog2(ENTRIES + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == CNT_W'(ENTRIES)));

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);

  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);

  // R9
  lookup_stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !lk_ready);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_rsp_valid |-> $past(lk_valid && lk_ready));
endmodule

bind vpid_inval_engine vpid_inval_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_rsp_valid(lk_rsp_valid)
);

// File: tb/test_vpid_inval_engine.sv
module test_vpid_inval_engine;
  localparam int N      = 8;
  localparam int VPID_W = 16;
  localparam int VA_W   = 48;
  localparam int PCID_W = 12;
  localparam int EPTP_W = 40;
  localparam int IDX_W  = 3;
  localparam int LPN_W  = VA_W - 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_type = 0;
  logic [VPID_W-1:0] cmd_vpid = 0;
  logic [VA_W-1:0] cmd_addr = 0;
  logic busy, done;
  logic fill_en = 0;
  logic [IDX_W-1:0] fill_idx = 0;
  logic [VPID_W-1:0] fill_vpid = 0;
  logic [LPN_W-1:0] fill_lpn = 0;
  logic [PCID_W-1:0] fill_pcid = 0;
  logic [EPTP_W-1:0] fill_eptp = 0;
  logic fill_global = 0;
  logic lk_valid = 0, lk_ready;
  logic [VPID_W-1:0] lk_vpid = 0;
  logic [LPN_W-1:0] lk_lpn = 0;
  logic [PCID_W-1:0] lk_pcid = 0;
  logic [EPTP_W-1:0] lk_eptp = 0;
  logic lk_rsp_valid, lk_hit;

  always #2 clk = ~clk;

  vpid_inval_engine #(.ENTRIES(N), .VPID_W(VPID_W), .VA_W(VA_W),
                      .PCID_W(PCID_W), .EPTP_W(EPTP_W)) i_vpid_inval_engine (.*);

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit      m_vld[N];
  int      m_vpid[N];
  longint  m_lpn[N];
  int      m_pcid[N];
  longint  m_eptp[N];
  bit      m_glb[N];
  int      left = 0;
  bit      e_done = 0, e_rsp = 0, e_hit = 0;

  function automatic bit m_sel(int i, int kind, int cv, longint cl);
    if (!m_vld[i] || m_vpid[i] == 0) return 0;
    case (kind)
      0: return (m_vpid[i] == cv) && (m_lpn[i] == cl);
      1: return m_vpid[i] == cv;
      2: return 1;
      default: return (m_vpid[i] == cv) && !m_glb[i];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      left = 0; e_done = 0; e_rsp = 0; e_hit = 0;
    end else begin
      bit was_busy;
      was_busy = (left > 0);
      e_done = 0;
      if (left > 0) begin
        left--;
        if (left == 0) e_done = 1;
      end
      e_rsp = lk_valid && !was_busy;
      e_hit = 0;
      if (e_rsp)
        for (int i = 0; i < N; i++)
          if (m_vld[i] && m_vpid[i] == int'(lk_vpid) && m_lpn[i] == longint'(lk_lpn) &&
              m_pcid[i] == int'(lk_pcid) && m_eptp[i] == longint'(lk_eptp))
            e_hit = 1;
      if (fill_en && !was_busy) begin
        m_vld[fill_idx]  = 1;
        m_vpid[fill_idx] = int'(fill_vpid);
        m_lpn[fill_idx]  = longint'(fill_lpn);
        m_pcid[fill_idx] = int'(fill_pcid);
        m_eptp[fill_idx] = longint'(fill_eptp);
        m_glb[fill_idx]  = fill_global;
      end
      if (cmd_valid && !was_busy) begin
        for (int i = 0; i < N; i++)
          if (m_sel(i, int'(cmd_type), int'(cmd_vpid), longint'(cmd_addr >> 12)))
            m_vld[i] = 0;
        left = N;
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy === (left > 0), "R7", busy, left > 0);
      chk(done === e_done, "R7", done, e_done);
      chk(cmd_ready === !(left > 0), "R8", cmd_ready, !(left > 0));
      chk(lk_ready === !(left > 0), "R9", lk_ready, !(left > 0));
      chk(lk_rsp_valid === e_rsp, "R9", lk_rsp_valid, e_rsp);
      if (e_rsp) chk(lk_hit === e_hit, cur_req, lk_hit, e_hit);
    end
  end

  // Slot table used by the directed checks
  int     t_vpid[N] = '{5, 5, 5, 9, 9, 0, 0, 12};
  longint t_lpn[N]  = '{'h100, 'h101, 'h100, 'h100, 'h200, 'h100, 'h300, 'h400};
  int     t_pcid[N] = '{1, 2, 7, 1, 3, 1, 4, 5};
  longint t_eptp[N] = '{1, 3, 9, 1, 2, 1, 6, 8};
  bit     t_glb[N]  = '{0, 1, 0, 0, 1, 0, 1, 0};

  task automatic fill_slot(input int i);
    @(negedge clk);
    fill_en = 1; fill_idx = IDX_W'(i);
    fill_vpid = VPID_W'(t_vpid[i]); fill_lpn = LPN_W'(t_lpn[i]);
    fill_pcid = PCID_W'(t_pcid[i]); fill_eptp = EPTP_W'(t_eptp[i]);
    fill_global = t_glb[i];
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input int v, input longint l, input int p, input longint e,
                      input bit exp, input string req);
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    cur_req = req;
    lk_valid = 1; lk_vpid = VPID_W'(v); lk_lpn = LPN_W'(l);
    lk_pcid = PCID_W'(p); lk_eptp = EPTP_W'(e);
    @(negedge clk);
    lk_valid = 0;
    chk(lk_rsp_valid && (lk_hit == exp), req, lk_hit, exp);
  endtask

  task automatic look_slot(input int i, input bit exp, input string req);
    look(t_vpid[i], t_lpn[i], t_pcid[i], t_eptp[i], exp, req);
  endtask

  task automatic inval(input int kind, input int v, input longint addr);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_type = 2'(kind); cmd_vpid = VPID_W'(v); cmd_addr = VA_W'(addr);
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == N && done, "R7", n, N);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !lk_rsp_valid && cmd_ready, "R11", busy, 0);
    rst = 0;
    // R11: reset leaves nothing valid
    look(0, 0, 0, 0, 0, "R11");
    look(5, 'h100, 1, 1, 0, "R11");
    for (int i = 0; i < N; i++) fill_slot(i);
    // R10: filled slots visible
    for (int i = 0; i < N; i++) look_slot(i, 1, "R10");

    // R1/R5: kind 0, page 0x100 of VPID 5 with nonzero offset
    inval(0, 5, (longint'('h100) << 12) | 'habc);
    look_slot(0, 0, "R1");
    look_slot(2, 0, "R5");
    look_slot(1, 1, "R1");
    look_slot(3, 1, "R1");
    look_slot(5, 1, "R6");

    // R4: kind 3 on VPID 9 keeps the global entry
    inval(3, 9, 0);
    look_slot(3, 0, "R4");
    look_slot(4, 1, "R4");
    look_slot(7, 1, "R4");

    // R2: kind 1 on VPID 5 removes the global one too
    inval(1, 5, 0);
    look_slot(1, 0, "R2");
    look_slot(4, 1, "R2");

    // R6: kind 1 on VPID 0 removes nothing
    inval(1, 0, 0);
    look_slot(5, 1, "R6");
    look_slot(6, 1, "R6");

    // R3: kind 2 with an unrelated VPID field
    fill_slot(0);
    inval(2, 'h77, 0);
    look_slot(0, 0, "R3");
    look_slot(4, 0, "R3");
    look_slot(7, 0, "R3");
    look_slot(5, 1, "R6");
    look_slot(6, 1, "R6");

    // R8/R9/R10: probe a sweep mid-flight
    @(negedge clk);
    cmd_valid = 1; cmd_type = 2'd1; cmd_vpid = 16'h99; cmd_addr = 0;
    @(negedge clk);
    cmd_type = 2'd2;
    lk_valid = 1; lk_vpid = 0; lk_lpn = LPN_W'('h100); lk_pcid = 1; lk_eptp = 1;
    fill_en = 1; fill_idx = 3'd5; fill_vpid = 16'h77; fill_lpn = LPN_W'('h555);
    fill_pcid = 0; fill_eptp = 0; fill_global = 0;
    chk(!cmd_ready, "R8", cmd_ready, 0);
    chk(!lk_ready, "R9", lk_ready, 0);
    @(negedge clk);
    cmd_valid = 0; lk_valid = 0; fill_en = 0;
    chk(!lk_rsp_valid, "R9", lk_rsp_valid, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R8", busy, 0);
    look_slot(5, 1, "R10");
    look('h77, 'h555, 0, 0, 0, "R10");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule